// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This unit watches the live BCD time-of-day and date fields of a calendar and raises an alarm when they agree with a programmed 32-bit alarm word. Seconds, minutes, hours and a day field each carry their own don't-care bit, so one word can express "every minute at :30", "every day at 09:15:00" or "every Wednesday at noon". The day field holds either a day of month or a weekday, chosen by a selector bit in the word. The comparison is qualified by the calendar's one-second tick. A match therefore sets the flag once, on the tick that brings the calendar onto the alarm time, and never again inside that second.

Software reaches the unit through a small register port with three locations: the alarm word, a control register and a status register. To change the alarm word, software clears the alarm enable and then waits for the write-allowed status bit. That bit comes from a gate state machine with three states. WG_OPEN means the word is writable and is the reset state. WG_ARMED means the alarm is enabled and the word is locked. WG_DRAIN is the countdown after disabling. The transitions are: OPEN→ARMED on a control write that sets the enable; ARMED→DRAIN on a control write that clears it; DRAIN→ARMED on a control write that sets it again; DRAIN→OPEN once SYNC_CYCLES cycles have elapsed. The alarm flag is held by a second state machine. FL_IDLE goes to FL_PENDING on a qualified match. FL_PENDING goes back to FL_IDLE on a status write with bit 8 low, unless a match arrives in the same cycle. The interrupt output follows the flag gated by the interrupt enable.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset the alarm word and control register read 0, the status register reads 0x0000_0001 (write-allowed set, flag clear) and irq_o is 0.
- R2: Control bit 8 is the alarm enable. A control write that clears it, made while it was set, makes status bit 0 read 1 exactly SYNC_CYCLES (default 2) clock cycles after that write. Status bit 0 reads 0 from the cycle after a control write that sets the enable.
- R3: A write to the alarm word (address 0) while status bit 0 is 0 is dropped, and the word keeps its old value.
- R4: The alarm word holds seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16 and the day in bits 29:24. With the enable set, a tick_i pulse while every unmasked field equals the calendar sets status bit 8. Any unmasked field that differs prevents it.
- R5: Mask bits 7, 15, 23 and 31 make seconds, minutes, hours and day don't-care respectively.
- R6: With bit 30 set, bits 27:24 are compared with the weekday input (1 to 7). With bit 30 clear, bits 29:24 are compared with the BCD day of month.
- R7: Control bit 6 selects 12-hour mode. When it is 0, alarm bit 22 (PM) is ignored. When it is 1, bit 22 must equal cal_pm_i.
- R8: Status bit 8 is sticky. A status write with bit 8 = 0 clears it, and a status write with bit 8 = 1 leaves it set. Later matching or non-matching ticks do not clear it.
- R9: irq_o is 1 exactly while status bit 8 and control bit 12 (interrupt enable) are both 1.
- R10: No flag is set without a tick_i pulse, and no flag is set while the alarm enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 alarm word, 1 control, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_i | input | 1 | One-cycle pulse when the calendar fields have just advanced |
| cal_sec_i | input | 7 | Current seconds, BCD |
| cal_min_i | input | 7 | Current minutes, BCD |
| cal_hour_i | input | 6 | Current hours, BCD |
| cal_pm_i | input | 1 | Current PM indicator (12-hour mode) |
| cal_date_i | input | 6 | Current day of month, BCD |
| cal_wday_i | input | 3 | Current weekday, 1 to 7 |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions check on every cycle that a locked alarm word cannot change and that write-allowed is never seen together with the enable. They also check that the flag can only rise on an enabled tick, that it stays set unless a clearing status write arrives, and that the interrupt never appears without the flag. The bench's scenarios are needed for the exact drain latency, the field encodings, the per-field masks, the day-of-month versus weekday selection and the PM handling in each hour mode. These depend on specific word and calendar values that a per-cycle property cannot enumerate.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int ALM_W = 32;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] A_WORD = 2'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] A_STAT = 2'd2;

    // alarm word field positions
    localparam int SEC_LSB  = 0;
    localparam int SEC_W    = 7;
    localparam int SEC_DC   = 7;
    localparam int MIN_LSB  = 8;
    localparam int MIN_W    = 7;
    localparam int MIN_DC   = 15;
    localparam int HR_LSB   = 16;
    localparam int HR_W     = 6;
    localparam int HR_PM    = 22;
    localparam int HR_DC    = 23;
    localparam int DAY_LSB  = 24;
    localparam int DAY_W    = 6;
    localparam int WDAY_W   = 4;
    localparam int DAY_SEL  = 30;
    localparam int DAY_DC   = 31;

    // control and status bit positions
    localparam int C_FMT12  = 6;
    localparam int C_ENA    = 8;
    localparam int C_IE     = 12;
    localparam int S_WOK    = 0;
    localparam int S_FLAG   = 8;

    localparam int N_FIELDS = 4;

    typedef enum logic [1:0] {
        WG_OPEN  = 2'd0,
        WG_ARMED = 2'd1,
        WG_DRAIN = 2'd2
    } wgate_state_t;

    typedef enum logic {
        FL_IDLE    = 1'b0,
        FL_PENDING = 1'b1
    } flag_state_t;

endpackage

// File: rtl/cal_alarm_wrgate.sv
module cal_alarm_wrgate
    import cal_alarm_pkg::*;
#(
    parameter int SYNC_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic ena_wdata_i,
    output logic wr_ok_o
);
    localparam int CNT_W = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYCLES - 1);

    wgate_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WG_OPEN: begin
                if (ctrl_wr_i && ena_wdata_i) state_d = WG_ARMED;
            end
            WG_ARMED: begin
                if (ctrl_wr_i && !ena_wdata_i) begin
                    state_d = WG_DRAIN;
                    cnt_d   = '0;
                end
            end
            WG_DRAIN: begin
                if (ctrl_wr_i && ena_wdata_i) begin
                    state_d = WG_ARMED;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = WG_OPEN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = WG_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WG_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wr_ok_o = (state_q == WG_OPEN);
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic [ALM_W-1:0] word_i,
    input  logic             fmt12_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [MIN_W-1:0] min_i,
    input  logic [HR_W-1:0]  hour_i,
    input  logic             pm_i,
    input  logic [DAY_W-1:0] date_i,
    input  logic [2:0]       wday_i,
    output logic             hit_o
);
    logic [N_FIELDS-1:0] eq;
    logic [N_FIELDS-1:0] dc;
    logic                pm_ok;
    logic                day_eq;

    always_comb begin
        pm_ok  = !fmt12_i || (word_i[HR_PM] == pm_i);
        day_eq = word_i[DAY_SEL]
               ? (word_i[DAY_LSB +: WDAY_W] == {1'b0, wday_i})
               : (word_i[DAY_LSB +: DAY_W]  == date_i);
        eq[0] = (word_i[SEC_LSB +: SEC_W] == sec_i);
        eq[1] = (word_i[MIN_LSB +: MIN_W] == min_i);
        eq[2] = (word_i[HR_LSB  +: HR_W]  == hour_i) && pm_ok;
        eq[3] = day_eq;
        dc    = {word_i[DAY_DC], word_i[HR_DC], word_i[MIN_DC], word_i[SEC_DC]};
    end

    logic [N_FIELDS-1:0] fld_ok;
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        assign fld_ok[g] = eq[g] | dc[g];
    end

    assign hit_o = &fld_ok;

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clear_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:    if (event_i) state_d = FL_PENDING;
            FL_PENDING: if (clear_i && !event_i) state_d = FL_IDLE;
            default:    state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FL_PENDING);
    end

endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int SYNC_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [ALM_W-1:0]  bus_wdata,
    output logic [ALM_W-1:0]  bus_rdata,
    input  logic              tick_i,
    input  logic [SEC_W-1:0]  cal_sec_i,
    input  logic [MIN_W-1:0]  cal_min_i,
    input  logic [HR_W-1:0]   cal_hour_i,
    input  logic              cal_pm_i,
    input  logic [DAY_W-1:0]  cal_date_i,
    input  logic [2:0]        cal_wday_i,
    output logic              irq_o
);
    logic [ALM_W-1:0] word_q;
    logic ena_q, ie_q, fmt12_q;
    logic wr_ok, hit, flag;
    logic wr_word, wr_ctrl, wr_stat;

    assign wr_word = bus_wr && (bus_addr == A_WORD);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);

    cal_alarm_wrgate #(.SYNC_CYCLES(SYNC_CYCLES)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (wr_ctrl),
        .ena_wdata_i(bus_wdata[C_ENA]),
        .wr_ok_o    (wr_ok)
    );

    cal_alarm_match u_match (
        .word_i (word_q),
        .fmt12_i(fmt12_q),
        .sec_i  (cal_sec_i),
        .min_i  (cal_min_i),
        .hour_i (cal_hour_i),
        .pm_i   (cal_pm_i),
        .date_i (cal_date_i),
        .wday_i (cal_wday_i),
        .hit_o  (hit)
    );

    cal_alarm_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .event_i(tick_i && ena_q && hit),
        .clear_i(wr_stat && !bus_wdata[S_FLAG]),
        .flag_o (flag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            ena_q   <= 1'b0;
            ie_q    <= 1'b0;
            fmt12_q <= 1'b0;
        end else begin
            if (wr_word && wr_ok) word_q <= bus_wdata;
            if (wr_ctrl) begin
                ena_q   <= bus_wdata[C_ENA];
                ie_q    <= bus_wdata[C_IE];
                fmt12_q <= bus_wdata[C_FMT12];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_WORD: bus_rdata = word_q;
            A_CTRL: begin
                bus_rdata[C_ENA]   = ena_q;
                bus_rdata[C_IE]    = ie_q;
                bus_rdata[C_FMT12] = fmt12_q;
            end
            A_STAT: begin
                bus_rdata[S_WOK]  = wr_ok;
                bus_rdata[S_FLAG] = flag;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = flag & ie_q;

endmodule

// File: rtl/cal_alarm_unit_chk.sv
module cal_alarm_unit_chk
    import cal_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [ALM_W-1:0]  bus_wdata,
    input logic              tick_i,
    input logic              irq_o,
    input logic [ALM_W-1:0]  word_q,
    input logic              ena_q,
    input logic              wr_ok,
    input logic              flag
);
    // R3: locked word cannot change
    a_r3_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_WORD && !wr_ok) |=> $stable(word_q));

    // R2: write-allowed never coexists with the enable
    a_r2_open_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> !ena_q);

    // R8: flag holds unless a clearing status write arrives
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_wr && bus_addr == A_STAT && !bus_wdata[S_FLAG])) |=> flag);

    // R10: flag rises only on an enabled tick
    a_r10_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick_i && ena_q));

    // R9: interrupt never without the flag
    a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);

endmodule

bind cal_alarm_unit cal_alarm_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .tick_i   (tick_i),
    .irq_o    (irq_o),
    .word_q   (word_q),
    .ena_q    (ena_q),
    .wr_ok    (wr_ok),
    .flag     (flag)
);

// File: tb/tb_cal_alarm_unit.sv
`timescale 1ns/1ps
module tb_cal_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_i = 1'b0;
    logic [6:0]  cal_sec_i = '0;
    logic [6:0]  cal_min_i = '0;
    logic [5:0]  cal_hour_i = '0;
    logic        cal_pm_i = 1'b0;
    logic [5:0]  cal_date_i = 6'h01;
    logic [2:0]  cal_wday_i = 3'd1;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cal_alarm_unit dut (.*);

    localparam logic [31:0] ENA = 32'h100, IE = 32'h1000, F12 = 32'h40;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    function automatic logic [31:0] mk(input logic [6:0] s, input logic ms,
        input logic [6:0] m, input logic mm, input logic [5:0] h, input logic pm,
        input logic mh, input logic [5:0] d, input logic wsel, input logic md);
        return {md, wsel, d, mh, pm, h, mm, m, ms, s};
    endfunction

    task automatic arm(input logic [31:0] w, input logic [31:0] ctl);
        wr(2'd1, ctl & ~ENA);
        cyc(3);
        wr(2'd0, w);
        wr(2'd1, ctl | ENA);
    endtask

    task automatic setcal(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
        input logic pm, input logic [5:0] d, input logic [2:0] wd);
        cal_sec_i = s; cal_min_i = m; cal_hour_i = h; cal_pm_i = pm;
        cal_date_i = d; cal_wday_i = wd;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic flag_is(input string req, input logic exp);
        logic [31:0] st;
        rd(2'd2, st);
        check(req, {31'd0, st[8]}, {31'd0, exp});
    endtask

    task automatic clr();
        wr(2'd2, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 word", v, 32'h0);
        rd(2'd1, v); check("R1 ctrl", v, 32'h0);
        rd(2'd2, v); check("R1 status", v, 32'h1);
        check("R1 irq", {31'd0, irq_o}, 32'h0);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        wr(2'd1, ENA);
        rd(2'd2, v); check("R2 armed closes", {31'd0, v[0]}, 32'h0);
        wr(2'd1, 32'h0);
        rd(2'd2, v); check("R2 drain 0", {31'd0, v[0]}, 32'h0);
        cyc(1);
        rd(2'd2, v); check("R2 drain 1", {31'd0, v[0]}, 32'h0);
        cyc(1);
        rd(2'd2, v); check("R2 open after 2", {31'd0, v[0]}, 32'h1);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        arm(32'h0000_1122, 32'h0);
        wr(2'd0, 32'h1234_5678);
        rd(2'd0, v); check("R3 dropped write", v, 32'h0000_1122);
    endtask

    task automatic t_full();
        arm(mk(7'h30,0,7'h15,0,6'h09,0,0,6'h21,0,0), 32'h0);
        setcal(7'h30, 7'h15, 6'h09, 0, 6'h21, 3'd2);
        cyc(2);
        flag_is("R10 no tick no flag", 1'b0);
        tick();
        flag_is("R4 full match", 1'b1);
        clr();
        flag_is("R8 cleared", 1'b0);
        setcal(7'h31, 7'h15, 6'h09, 0, 6'h21, 3'd2);
        tick();
        flag_is("R4 seconds differ", 1'b0);
        setcal(7'h30, 7'h15, 6'h09, 0, 6'h22, 3'd2);
        tick();
        flag_is("R4 date differs", 1'b0);
    endtask

    task automatic t_masks();
        arm(mk(7'h00,1,7'h00,1,6'h09,0,0,6'h01,0,1), 32'h0);
        setcal(7'h47, 7'h58, 6'h09, 0, 6'h17, 3'd5);
        tick();
        flag_is("R5 masked sec/min/day", 1'b1);
        clr();
        setcal(7'h47, 7'h58, 6'h10, 0, 6'h17, 3'd5);
        tick();
        flag_is("R5 unmasked hour differs", 1'b0);
        arm(mk(7'h05,0,7'h00,1,6'h00,0,1,6'h01,0,1), 32'h0);
        setcal(7'h05, 7'h33, 6'h23, 0, 6'h30, 3'd7);
        tick();
        flag_is("R5 hour mask", 1'b1);
        clr();
    endtask

    task automatic t_weekday();
        arm(mk(7'h00,0,7'h00,0,6'h12,0,0,6'h03,1,0), 32'h0);
        setcal(7'h00, 7'h00, 6'h12, 0, 6'h05, 3'd3);
        tick();
        flag_is("R6 weekday match", 1'b1);
        clr();
        setcal(7'h00, 7'h00, 6'h12, 0, 6'h03, 3'd4);
        tick();
        flag_is("R6 weekday differs, date equal", 1'b0);
        arm(mk(7'h00,0,7'h00,0,6'h12,0,0,6'h03,0,0), 32'h0);
        tick();
        flag_is("R6 date mode", 1'b1);
        clr();
    endtask

    task automatic t_pm();
        arm(mk(7'h00,0,7'h00,0,6'h09,1,0,6'h01,0,1), 32'h0);
        setcal(7'h00, 7'h00, 6'h09, 0, 6'h01, 3'd1);
        tick();
        flag_is("R7 PM ignored 24h", 1'b1);
        clr();
        arm(mk(7'h00,0,7'h00,0,6'h09,1,0,6'h01,0,1), F12);
        tick();
        flag_is("R7 12h PM differs", 1'b0);
        cal_pm_i = 1'b1;
        tick();
        flag_is("R7 12h PM equal", 1'b1);
        clr();
    endtask

    task automatic t_sticky_irq();
        arm(mk(7'h00,1,7'h00,1,6'h00,0,1,6'h01,0,1), 32'h0);
        tick();
        flag_is("R8 set", 1'b1);
        check("R9 irq off without ie", {31'd0, irq_o}, 32'h0);
        wr(2'd2, 32'h100);
        flag_is("R8 write 1 keeps", 1'b1);
        wr(2'd1, ENA | IE);
        check("R9 irq with ie", {31'd0, irq_o}, 32'h1);
        wr(2'd0, 32'h0);
        setcal(7'h11, 7'h11, 6'h11, 0, 6'h11, 3'd1);
        tick();
        flag_is("R8 holds across tick", 1'b1);
        clr();
        flag_is("R8 write 0 clears", 1'b0);
        check("R9 irq drops", {31'd0, irq_o}, 32'h0);
    endtask

    task automatic t_disabled();
        arm(mk(7'h00,1,7'h00,1,6'h00,0,1,6'h01,0,1), 32'h0);
        wr(2'd1, 32'h0);
        tick();
        flag_is("R10 disabled no flag", 1'b0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_handshake();
        t_locked();
        t_full();
        t_masks();
        t_weekday();
        t_pm();
        t_sticky_irq();
        t_disabled();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule